// File: doc/BRIEF.md
# Keyed Dual-Timeout Watchdog Timer

This block is a watchdog timer that counts ticks of a slow clock-enable input, `tick_en`, in a 26-bit counter. Software drives it through a small register port: a write strobe, a read strobe, an address and a data bus. Two timeouts watch the same counter. The wake-up timeout sets a timeout flag, and that flag drives the interrupt output. The reset timeout sets a reset-out flag and asks for a system reset with a pulse on `rst_req`. Each timeout has its own enable and its own period. A period is a power of two from 2^10 to 2^25 ticks.

Any command that changes configuration (wake-up setup, reset setup, start/stop) works only right after the right unlock key has been written. One unlock covers exactly one such command. A rejected command changes nothing and sets a sticky error bit. Feeding the watchdog, clearing flags and clearing the error bit need no key. A run-in-sleep bit chooses whether counting goes on while `sleep` is high.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, STATUS (address 6) reads 0, FLAGS (address 5) reads 0, COUNT (address 7) reads 0, and `irq` and `rst_req` are low. Addresses 0 to 4 always read 0.
- R2: A write of `KEY_VAL` (default 0xA5) to address 0 unlocks the block for exactly one configuration write, to address 1, 2 or 3. The write takes effect and the block locks again. STATUS bit 5 shows the unlocked state.
- R3: A configuration write while locked is ignored. So is any write to address 0 with a wrong key, which also locks the block. Both set the error bit, STATUS bit 4. Any write to address 6 clears that bit.
- R4: Address 1 (wake-up) and address 2 (reset) take an enable in data bit 5 and a period code in bits 4:0. Enable 0 disables the timeout. Enable 1 with a code of 16 or more is rejected and leaves the setting unchanged. STATUS bits 1/2 are the enables, and bits 12:8 and 20:16 are the wake-up and reset codes.
- R5: When the wake-up timeout is enabled with code c, the tick that takes the count to 2^(c+10) sets the timeout flag (FLAGS bit 0). `irq` is high exactly while that flag is set.
- R6: When the reset timeout is enabled, the tick that reaches its limit sets the reset-out flag (FLAGS bit 1). The same tick raises `rst_req`, which stays high until the next `tick_en` cycle, one tick period.
- R7: A write to address 5 clears each flag whose data bit is 1 and leaves the others unchanged. An expiry in the same cycle wins.
- R8: Any write to address 4 (feed) restarts the count at 0, with no key.
- R9: With STATUS bit 3 (run-in-sleep, data bit 1 of the address 3 write) at 0, the count holds while `sleep` is high. With it at 1, counting goes on during sleep.
- R10: An accepted address 3 write with data bit 0 = 1 starts the timer and clears the count. With bit 0 = 0 it stops the timer and holds the count. The count moves only in cycles with `tick_en` high while the timer runs (STATUS bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Watchdog tick, one clock wide |
| sleep | input | 1 | System sleep indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when `rd_en` is low |
| irq | output | 1 | Wake-up interrupt, follows the timeout flag |
| rst_req | output | 1 | Reset request pulse, one tick long |

## Verification
The main function is exercised with a dense tick (every cycle) and with a sparse tick (one cycle in three). These show whether the count, the expiry point and the `rst_req` width follow `tick_en` or the raw clock. The expiry is probed one tick before and exactly at 2^10 and 2^11. This separates a compare against the right power of two from an off-by-one or a wrong code offset. Sleep is applied with run-in-sleep both clear and set, which shows the pause is tied to that bit. Key sequences cover locked, wrong-key, single-use and illegal-code writes, and each is read back through STATUS.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  // Register addresses; software depends on these values.
  typedef enum logic [2:0] {
    RA_KEY   = 3'd0,
    RA_WAKE  = 3'd1,
    RA_RESET = 3'd2,
    RA_RUN   = 3'd3,
    RA_FEED  = 3'd4,
    RA_FLAGS = 3'd5,
    RA_STAT  = 3'd6,
    RA_COUNT = 3'd7
  } wdt_reg_e;

  // STATUS bit positions
  localparam int ST_RUN   = 0;
  localparam int ST_WEN   = 1;
  localparam int ST_REN   = 2;
  localparam int ST_SRUN  = 3;
  localparam int ST_ERR   = 4;
  localparam int ST_UNL   = 5;
  localparam int ST_WSEL  = 8;
  localparam int ST_RSEL  = 16;
endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate #(
  parameter int          KEY_W   = 8,
  parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_in,
  input  logic             cfg_wr,
  input  logic             err_clr,
  output logic             unlocked,
  output logic             cfg_ok,
  output logic             key_err
);
  logic key_match;
  assign key_match = (key_in == KEY_VAL);
  assign cfg_ok    = cfg_wr & unlocked;

  // One unlock covers one configuration write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= key_match;
    else if (cfg_wr) unlocked <= 1'b0;
  end

  // Sticky error; a new error wins over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    key_err <= 1'b0;
    else if ((key_wr && !key_match) || (cfg_wr && !unlocked)) key_err <= 1'b1;
    else if (err_clr)                              key_err <= 1'b0;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 26,
  parameter int SEL_W    = 5,
  parameter int PER_BASE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sleep,
  input  logic             running,
  input  logic             sleep_run,
  input  logic             clr,
  input  logic             wake_en,
  input  logic [SEL_W-1:0] wake_sel,
  input  logic             rst_en,
  input  logic [SEL_W-1:0] rst_sel,
  output logic [CNT_W-1:0] count,
  output logic             advance,
  output logic             wake_evt,
  output logic             rst_evt
);
  // Count value at which a timeout with code s expires.
  function automatic logic [CNT_W-1:0] limit_of(input logic [SEL_W-1:0] s);
    logic [CNT_W-1:0] one;
    one    = '0;
    one[0] = 1'b1;
    return one << (PER_BASE + int'(s));
  endfunction

  logic [CNT_W-1:0] inc;

  assign advance  = running & tick_en & (~sleep | sleep_run);
  assign inc      = count + CNT_W'(1);
  assign wake_evt = advance & wake_en & (inc == limit_of(wake_sel));
  assign rst_evt  = advance & rst_en  & (inc == limit_of(rst_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clr)     count <= '0;
    else if (advance) count <= inc;
  end
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wake_evt,
  input  logic       rst_evt,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,
  output logic       to_flag,
  output logic       ro_flag,
  output logic       rst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_flag <= 1'b0;
      ro_flag <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      to_flag <= wake_evt | (to_flag & ~(clr_wr & clr_mask[0]));
      ro_flag <= rst_evt  | (ro_flag & ~(clr_wr & clr_mask[1]));
      if (rst_evt)      rst_req <= 1'b1;
      else if (tick_en) rst_req <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int               CNT_W    = 26,
  parameter int               SEL_W    = 5,
  parameter int               PER_BASE = 10,
  parameter int               NUM_PER  = 16,
  parameter int               KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_VAL  = 8'hA5,
  parameter int               ADDR_W   = 3,
  parameter int               DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              sleep,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int EN_BIT = SEL_W;

  function automatic logic sel_legal(input logic [SEL_W-1:0] s);
    return int'(s) < NUM_PER;
  endfunction

  // Decoded strobes
  logic key_wr, wake_wr, rstc_wr, run_wr, feed_wr, flag_wr, stat_wr, cfg_wr;
  assign key_wr  = wr_en && (addr == ADDR_W'(RA_KEY));
  assign wake_wr = wr_en && (addr == ADDR_W'(RA_WAKE));
  assign rstc_wr = wr_en && (addr == ADDR_W'(RA_RESET));
  assign run_wr  = wr_en && (addr == ADDR_W'(RA_RUN));
  assign feed_wr = wr_en && (addr == ADDR_W'(RA_FEED));
  assign flag_wr = wr_en && (addr == ADDR_W'(RA_FLAGS));
  assign stat_wr = wr_en && (addr == ADDR_W'(RA_STAT));
  assign cfg_wr  = wake_wr | rstc_wr | run_wr;

  logic unlocked, cfg_ok, key_err;

  wdt_keygate #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_in   (wdata[KEY_W-1:0]),
    .cfg_wr   (cfg_wr),
    .err_clr  (stat_wr),
    .unlocked (unlocked),
    .cfg_ok   (cfg_ok),
    .key_err  (key_err)
  );

  // Configuration state
  logic             running, sleep_run, wake_en, rst_en;
  logic [SEL_W-1:0] wake_sel, rst_sel;
  logic [SEL_W-1:0] code_in;
  logic             code_ok, start_cmd, count_clr;

  assign code_in   = wdata[SEL_W-1:0];
  assign code_ok   = sel_legal(code_in);
  assign start_cmd = cfg_ok && run_wr && wdata[0];
  assign count_clr = feed_wr | start_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      sleep_run <= 1'b0;
      wake_en   <= 1'b0;
      rst_en    <= 1'b0;
      wake_sel  <= '0;
      rst_sel   <= '0;
    end else if (cfg_ok) begin
      if (wake_wr) begin
        if (!wdata[EN_BIT]) wake_en <= 1'b0;
        else if (code_ok) begin
          wake_en  <= 1'b1;
          wake_sel <= code_in;
        end
      end
      if (rstc_wr) begin
        if (!wdata[EN_BIT]) rst_en <= 1'b0;
        else if (code_ok) begin
          rst_en  <= 1'b1;
          rst_sel <= code_in;
        end
      end
      if (run_wr) begin
        running   <= wdata[0];
        sleep_run <= wdata[1];
      end
    end
  end

  logic [CNT_W-1:0] count;
  logic             advance, wake_evt, rst_evt;

  wdt_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PER_BASE(PER_BASE)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .sleep     (sleep),
    .running   (running),
    .sleep_run (sleep_run),
    .clr       (count_clr),
    .wake_en   (wake_en),
    .wake_sel  (wake_sel),
    .rst_en    (rst_en),
    .rst_sel   (rst_sel),
    .count     (count),
    .advance   (advance),
    .wake_evt  (wake_evt),
    .rst_evt   (rst_evt)
  );

  logic to_flag, ro_flag;

  wdt_flags u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wake_evt (wake_evt),
    .rst_evt  (rst_evt),
    .clr_wr   (flag_wr),
    .clr_mask (wdata[1:0]),
    .to_flag  (to_flag),
    .ro_flag  (ro_flag),
    .rst_req  (rst_req)
  );

  assign irq = to_flag;

  // Read mux
  logic [DATA_W-1:0] stat_word;
  always_comb begin
    stat_word                   = '0;
    stat_word[ST_RUN]           = running;
    stat_word[ST_WEN]           = wake_en;
    stat_word[ST_REN]           = rst_en;
    stat_word[ST_SRUN]          = sleep_run;
    stat_word[ST_ERR]           = key_err;
    stat_word[ST_UNL]           = unlocked;
    stat_word[ST_WSEL +: SEL_W] = wake_sel;
    stat_word[ST_RSEL +: SEL_W] = rst_sel;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(RA_FLAGS))      rdata[1:0]      = {ro_flag, to_flag};
      else if (addr == ADDR_W'(RA_STAT))  rdata           = stat_word;
      else if (addr == ADDR_W'(RA_COUNT)) rdata[CNT_W-1:0] = count;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W  = 26,
  parameter int ADDR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             sleep,
  input logic             sleep_run,
  input logic             cfg_wr,
  input logic             feed_wr,
  input logic             count_clr,
  input logic             unlocked,
  input logic             key_err,
  input logic [CNT_W-1:0] count,
  input logic             wake_evt,
  input logic             rst_evt,
  input logic             irq,
  input logic             rst_req
);
  assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !unlocked);

  assert_locked_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !unlocked) |=> key_err);

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wake_evt));

  assert_rst_one_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && tick_en && !rst_evt) |=> !rst_req);

  assert_feed_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    feed_wr |=> (count == '0));

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !sleep_run && !count_clr) |=> $stable(count));

  assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !count_clr) |=> $stable(count));
endmodule

bind keyed_wdt wdt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .sleep     (sleep),
  .sleep_run (sleep_run),
  .cfg_wr    (cfg_wr),
  .feed_wr   (feed_wr),
  .count_clr (count_clr),
  .unlocked  (unlocked),
  .key_err   (key_err),
  .count     (count),
  .wake_evt  (wake_evt),
  .rst_evt   (rst_evt),
  .irq       (irq),
  .rst_req   (rst_req)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
  localparam logic [7:0] KEY = 8'hA5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick_en = 1'b1, sleep = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int checks = 0, errors = 0, cyc = 0;
  bit sparse = 1'b0, done = 1'b0;

  keyed_wdt #(.KEY_VAL(KEY)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sleep(sleep),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit      m_run = 0, m_sis = 0, m_wen = 0, m_ren = 0, m_err = 0, m_unl = 0;
  int      m_wsel = 0, m_rsel = 0;
  longint  m_cnt = 0;
  bit      m_tf = 0, m_rf = 0, m_rreq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_sis = 0; m_wen = 0; m_ren = 0; m_err = 0; m_unl = 0;
      m_wsel = 0; m_rsel = 0; m_cnt = 0; m_tf = 0; m_rf = 0; m_rreq = 0;
    end else begin
      bit adv, we, re;
      longint nxt, nc;
      adv = m_run && tick_en && (!sleep || m_sis);
      nxt = (m_cnt + 1) % (64'd1 << 26);
      we  = adv && m_wen && (nxt == (64'd1 << (m_wsel + 10)));
      re  = adv && m_ren && (nxt == (64'd1 << (m_rsel + 10)));
      nc  = adv ? nxt : m_cnt;
      m_tf   = we || (m_tf && !(wr_en && addr == 5 && wdata[0]));
      m_rf   = re || (m_rf && !(wr_en && addr == 5 && wdata[1]));
      m_rreq = re ? 1'b1 : (tick_en ? 1'b0 : m_rreq);
      if (wr_en) begin
        case (addr)
          3'd0: if (wdata[7:0] == KEY) m_unl = 1; else begin m_unl = 0; m_err = 1; end
          3'd1, 3'd2, 3'd3: begin
            if (!m_unl) m_err = 1;
            else begin
              m_unl = 0;
              if (addr == 3) begin
                m_run = wdata[0]; m_sis = wdata[1];
                if (wdata[0]) nc = 0;
              end else if (!wdata[5]) begin
                if (addr == 1) m_wen = 0; else m_ren = 0;
              end else if (wdata[4:0] < 16) begin
                if (addr == 1) begin m_wen = 1; m_wsel = int'(wdata[4:0]); end
                else begin m_ren = 1; m_rsel = int'(wdata[4:0]); end
              end
            end
          end
          3'd4: nc = 0;
          3'd6: m_err = 0;
          default: ;
        endcase
      end
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd5: v = {30'd0, m_rf, m_tf};
      3'd6: v = {11'd0, 5'(m_rsel), 3'd0, 5'(m_wsel), 2'd0, m_unl, m_err, m_sis, m_ren, m_wen, m_run};
      3'd7: v = 32'(m_cnt);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    #1;
    if (rst_n && !done) begin
      chk("R5 irq vs model", {31'd0, irq}, {31'd0, m_tf});
      chk("R6 rst_req vs model", {31'd0, rst_req}, {31'd0, m_rreq});
      if (rd_en) chk("R2 R7 R10 rdata vs model", rdata, model_read(addr));
    end
  end

  // Tick generator: every cycle, or one cycle in three
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      tick_en = !sparse || (ph == 0);
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    #1 chk(tag, rdata, exp);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_get(input logic [2:0] a, output logic [31:0] v);
    rd_en = 1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int width;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(3'd6, 32'h0, "R1 status after reset");
    rd(3'd5, 32'h0, "R1 flags after reset");
    rd(3'd7, 32'h0, "R1 count after reset");
    rd(3'd0, 32'h0, "R1 key address reads zero");
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 rst_req low", {31'd0, rst_req}, 32'd0);

    // R3 locked write, wrong key
    wr(3'd1, 32'h20);
    rd(3'd6, 32'h10, "R3 locked write ignored, error set");
    wr(3'd6, 32'h0);
    rd(3'd6, 32'h0, "R3 error cleared");
    wr(3'd0, 32'h3C);
    wr(3'd1, 32'h20);
    rd(3'd6, 32'h10, "R3 wrong key keeps block locked");
    wr(3'd6, 32'h0);

    // R2 single-use unlock
    wr(3'd0, 32'(KEY));
    rd(3'd6, 32'h20, "R2 unlocked shown");
    wr(3'd1, 32'h20);
    rd(3'd6, 32'h02, "R2 wake enabled code 0, relocked");
    wr(3'd1, 32'h00);
    rd(3'd6, 32'h12, "R2 second write without key ignored");
    wr(3'd6, 32'h0);
    wr(3'd0, 32'(KEY));
    wr(3'd2, 32'h21);
    rd(3'd6, 32'h00010006, "R2 reset enabled code 1");

    // R4 illegal code
    wr(3'd0, 32'(KEY));
    wr(3'd1, 32'h34);
    rd(3'd6, 32'h00010006, "R4 illegal code rejected");

    // R5 wake expiry at 1024 ticks
    wr(3'd0, 32'(KEY));
    wr(3'd3, 32'h1);
    idle(1023);
    chk("R5 irq low at count 1023", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R5 irq high at count 1024", {31'd0, irq}, 32'd1);

    // R7 write-one-to-clear
    wr(3'd5, 32'h2);
    chk("R7 mask of other bit leaves irq", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h1);
    chk("R7 mask clears timeout flag", {31'd0, irq}, 32'd0);

    // R8 feed, R6 reset expiry at 2048
    wr(3'd4, 32'h0);
    rd(3'd7, 32'h0, "R8 feed restarts count");
    idle(2046);
    chk("R6 rst_req low at 2047", {31'd0, rst_req}, 32'd0);
    idle(1);
    chk("R6 rst_req high at 2048", {31'd0, rst_req}, 32'd1);
    idle(1);
    chk("R6 rst_req one tick only", {31'd0, rst_req}, 32'd0);
    rd(3'd5, 32'h3, "R6 both flags set");
    wr(3'd5, 32'h3);
    rd(3'd5, 32'h0, "R7 flags cleared");

    // R9 sleep handling
    sleep = 1;
    rd_get(3'd7, v);
    idle(50);
    rd(3'd7, v, "R9 count holds in sleep");
    sleep = 0;
    wr(3'd0, 32'(KEY));
    wr(3'd3, 32'h3);
    sleep = 1;
    idle(10);
    rd(3'd7, 32'd10, "R9 count runs in sleep when enabled");
    sleep = 0;

    // R10 stop and sparse tick
    wr(3'd0, 32'(KEY));
    wr(3'd3, 32'h0);
    rd_get(3'd7, v);
    idle(20);
    rd(3'd7, v, "R10 stopped count holds");
    rd(3'd6, 32'h00010006, "R10 run bit clear");
    sparse = 1;
    wr(3'd0, 32'(KEY));
    wr(3'd3, 32'h1);
    for (int i = 0; i < 8000 && !rst_req; i++) idle(1);
    width = 0;
    for (int i = 0; i < 20 && rst_req; i++) begin width++; idle(1); end
    chk("R6 rst_req width with sparse tick", 32'(width), 32'd3);
    rd(3'd5, 32'h3, "R10 sparse tick expiries");
    sparse = 0;
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule